// File: doc/BRIEF.md
# Effective Address and Branch Unit

This unit sits after opcode decode in the pipeline of a small 8-bit processor with a 16-bit address space. Decode supplies an addressing-mode code, up to two operand bytes, the 8-bit index register and the address of the current opcode. From these inputs the unit computes four results: the operand's effective address, the instruction length in bytes, the next program counter, and whether a branch is taken.

For the bit test-and-branch form, the memory byte at the direct address is also supplied. The unit picks the bit named by the opcode and compares it with the wanted sense. It reports the bit so that the carry flag can be updated, and it forms the branch target from the third instruction byte.

All results are captured in one register stage. They appear with a valid strobe one clock after the request.

Top module: `eau_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, out_valid, ea, ilen, next_pc, taken and tested_bit are all zero.
- R2: The instruction length is set by the mode code. The codes are 0 immediate, 1 direct, 2 extended, 3 relative, 4 inherent, 5 indexed no offset, 6 indexed 8-bit offset, 7 indexed 16-bit offset, 8 bit set/clear and 9 bit test-and-branch. Modes 4 and 5 are one byte long. Modes 0, 1, 3, 6 and 8 are two bytes long. Modes 2, 7 and 9 are three bytes long. Codes 10 to 15 are handled as inherent: length 1, ea 0 and no branch.
- R3: In immediate mode, ea is pc+1, which is the address of the operand byte.
- R4: In direct and bit set/clear modes, ea is {8'h00, op1}. The upper address byte is therefore always zero.
- R5: In extended mode, ea is {op1, op2}, with op1 as the high byte.
- R6: In relative mode, a true cond_in makes next_pc equal to pc+2 plus the sign-extended op1, modulo 2^16, and sets taken. A false cond_in makes next_pc equal to pc+2 and clears taken. In both cases ea holds the branch target. A taken branch lands between -126 and +129 of pc.
- R7: In indexed no-offset mode, ea is the zero-extended index register.
- R8: In indexed 8-bit offset mode, ea is the unsigned sum op1+idx, so it never exceeds 0x1FE.
- R9: In indexed 16-bit offset mode, ea is {op1, op2}+idx, modulo 2^16.
- R10: In bit test-and-branch mode, ea is {8'h00, op1} and tested_bit is bit bit_sel of mem_byte. The branch is taken when tested_bit equals bit_sense, where 1 means branch if the bit is set. next_pc is then pc+3 plus the sign-extended op2, and otherwise pc+3.
- R11: In every mode other than relative and bit test-and-branch, taken and tested_bit are 0 and next_pc is pc plus the instruction length, modulo 2^16.
- R12: Results are registered. out_valid is in_valid delayed by one clock, and the other outputs hold their values while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| mode | input | 4 | Addressing-mode code |
| op1 | input | 8 | First byte after the opcode |
| op2 | input | 8 | Second byte after the opcode |
| idx | input | 8 | Index register |
| pc | input | 16 | Address of the opcode |
| cond_in | input | 1 | Branch condition for relative mode |
| bit_sel | input | 3 | Bit number for bit test-and-branch |
| bit_sense | input | 1 | 1 = branch if the bit is set, 0 = branch if it is clear |
| mem_byte | input | 8 | Memory byte at the direct address |
| out_valid | output | 1 | Registered results are valid |
| ea | output | 16 | Effective address |
| ilen | output | 2 | Instruction length in bytes |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch taken |
| tested_bit | output | 1 | Tested bit for the carry flag |

## Verification
The assertions compare each registered output with the request inputs of the cycle before, through $past. They therefore assume that every request is a single-cycle pulse, with all its fields stable in that cycle.

They also assume that pc, op1 and op2 carry whatever decode delivered. No legal range is imposed, so the wraparound cases are included.

The stimulus drives each request for exactly one cycle, with idle cycles between some of them. It covers every mode code, including the unused codes. It also covers offsets at both sign extremes, index and offset bytes at 0xFF, a pc near 0xFFFF to force wraparound, and all eight bit positions in both senses.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_IMM = 4'd0,
    M_DIR = 4'd1,
    M_EXT = 4'd2,
    M_REL = 4'd3,
    M_INH = 4'd4,
    M_IX0 = 4'd5,
    M_IX1 = 4'd6,
    M_IX2 = 4'd7,
    M_BSC = 4'd8,
    M_BTB = 4'd9
  } amode_t;

  function automatic logic [1:0] mode_len(input logic [MODE_W-1:0] m);
    case (m)
      M_INH, M_IX0:                       mode_len = 2'd1;
      M_IMM, M_DIR, M_REL, M_IX1, M_BSC:  mode_len = 2'd2;
      M_EXT, M_IX2, M_BTB:                mode_len = 2'd3;
      default:                            mode_len = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/eau_addr.sv
module eau_addr
  import eau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     op1,
  input  logic [DW-1:0]     op2,
  input  logic [DW-1:0]     idx,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     rel_target,
  output logic [AW-1:0]     ea,
  output logic [1:0]        ilen
);
  localparam int PADW = AW - DW;
  localparam int SW   = DW + 1;

  logic [AW-1:0] pg0_addr;
  logic [AW-1:0] ix0_addr;
  logic [SW-1:0] ix1_sum;
  logic [AW-1:0] ix1_addr;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] ix2_addr;
  logic [AW-1:0] imm_addr;

  assign pg0_addr = {{PADW{1'b0}}, op1};
  assign ix0_addr = {{PADW{1'b0}}, idx};
  assign ix1_sum  = {1'b0, op1} + {1'b0, idx};
  assign ix1_addr = {{(AW-SW){1'b0}}, ix1_sum};
  assign ext_addr = {op1, op2};
  assign ix2_addr = ext_addr + ix0_addr;
  assign imm_addr = pc + {{(AW-1){1'b0}}, 1'b1};
  assign ilen     = mode_len(mode);

  always_comb begin
    case (mode)
      M_IMM:        ea = imm_addr;
      M_DIR, M_BSC,
      M_BTB:        ea = pg0_addr;
      M_EXT:        ea = ext_addr;
      M_REL:        ea = rel_target;
      M_IX0:        ea = ix0_addr;
      M_IX1:        ea = ix1_addr;
      M_IX2:        ea = ix2_addr;
      default:      ea = '0;
    endcase
  end
endmodule

// File: rtl/eau_branch.sv
module eau_branch
  import eau_pkg::*;
#(
  parameter int DW = 8,
  localparam int BSW = $clog2(DW)
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              cond_in,
  input  logic [BSW-1:0]    bit_sel,
  input  logic              bit_sense,
  input  logic [DW-1:0]     mem_byte,
  output logic              taken,
  output logic              tested_bit
);
  logic [DW-1:0] sel_hot;
  logic          picked;

  for (genvar g = 0; g < DW; g++) begin : g_sel
    assign sel_hot[g] = (bit_sel == BSW'(g)) & mem_byte[g];
  end
  assign picked = |sel_hot;

  always_comb begin
    taken      = 1'b0;
    tested_bit = 1'b0;
    case (mode)
      M_REL: taken = cond_in;
      M_BTB: begin
        tested_bit = picked;
        taken      = (picked == bit_sense);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eau_target.sv
module eau_target
  import eau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     pc,
  input  logic [1:0]        ilen,
  input  logic [DW-1:0]     op1,
  input  logic [DW-1:0]     op2,
  input  logic              taken,
  output logic [AW-1:0]     rel_target,
  output logic [AW-1:0]     next_pc
);
  logic [AW-1:0] seq_pc;
  logic [DW-1:0] off;
  logic [AW-1:0] off_x;

  assign seq_pc     = pc + {{(AW-2){1'b0}}, ilen};
  assign off        = (mode == M_BTB) ? op2 : op1;
  assign off_x      = {{(AW-DW){off[DW-1]}}, off};
  assign rel_target = seq_pc + off_x;
  assign next_pc    = taken ? rel_target : seq_pc;
endmodule

// File: rtl/eau_top.sv
module eau_top
  import eau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int BSW = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     op1,
  input  logic [DW-1:0]     op2,
  input  logic [DW-1:0]     idx,
  input  logic [AW-1:0]     pc,
  input  logic              cond_in,
  input  logic [BSW-1:0]    bit_sel,
  input  logic              bit_sense,
  input  logic [DW-1:0]     mem_byte,
  output logic              out_valid,
  output logic [AW-1:0]     ea,
  output logic [1:0]        ilen,
  output logic [AW-1:0]     next_pc,
  output logic              taken,
  output logic              tested_bit
);
  logic [AW-1:0] c_ea, c_npc, c_rel;
  logic [1:0]    c_len;
  logic          c_taken, c_tbit;

  eau_branch #(.DW(DW)) u_br (
    .mode(mode), .cond_in(cond_in), .bit_sel(bit_sel), .bit_sense(bit_sense),
    .mem_byte(mem_byte), .taken(c_taken), .tested_bit(c_tbit)
  );

  eau_addr #(.AW(AW), .DW(DW)) u_ad (
    .mode(mode), .op1(op1), .op2(op2), .idx(idx), .pc(pc),
    .rel_target(c_rel), .ea(c_ea), .ilen(c_len)
  );

  eau_target #(.AW(AW), .DW(DW)) u_tg (
    .mode(mode), .pc(pc), .ilen(c_len), .op1(op1), .op2(op2),
    .taken(c_taken), .rel_target(c_rel), .next_pc(c_npc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      ea         <= '0;
      ilen       <= '0;
      next_pc    <= '0;
      taken      <= 1'b0;
      tested_bit <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea         <= c_ea;
        ilen       <= c_len;
        next_pc    <= c_npc;
        taken      <= c_taken;
        tested_bit <= c_tbit;
      end
    end
  end

  // R12: a result strobe follows every request by exactly one clock
  a_r12_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2: the length is always 1, 2 or 3
  a_r2_len_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ilen != 2'd0));

  // R4: direct and bit set/clear stay in page zero
  a_r4_page0: assert property (@(posedge clk) disable iff (rst)
    in_valid && (mode == M_DIR || mode == M_BSC) |=> ea[AW-1:DW] == '0);

  // R8: indexed 8-bit offset never passes 0x1FE
  a_r8_ix1_max: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode == M_IX1 |=> ea <= AW'(2 * ((1 << DW) - 1)));

  // R6: a relative branch that is not taken falls through by two bytes
  a_r6_fallthrough: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode == M_REL && !cond_in |=> !taken && next_pc == $past(pc) + AW'(2));

  // R6: a taken relative branch lands within -126..+129 of the opcode
  a_r6_span: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode == M_REL && cond_in |=>
      taken && ((next_pc - $past(pc) + AW'(126)) <= AW'(255)));

  // R11: non-branch modes never branch and never touch carry
  a_r11_no_branch: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode != M_REL && mode != M_BTB |=> !taken && !tested_bit);

  // R10: the branch decision of the bit test follows the tested bit and the sense
  a_r10_sense: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode == M_BTB |=> taken == (tested_bit == $past(bit_sense)));

  // R12: the outputs hold while no request arrives
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ea) && $stable(next_pc) && $stable(ilen));
endmodule

// File: tb/sim_eau_top.sv
module sim_eau_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] ea;
    logic [1:0]  len;
    logic [15:0] npc;
    logic        tk;
    logic        tb;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] op1 = '0, op2 = '0, idx = '0, mem_byte = '0;
  logic [15:0] pc = '0;
  logic cond_in = 1'b0, bit_sense = 1'b0;
  logic [2:0] bit_sel = '0;
  logic out_valid, taken, tested_bit;
  logic [15:0] ea, next_pc;
  logic [1:0] ilen;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eau_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .op1(op1), .op2(op2),
    .idx(idx), .pc(pc), .cond_in(cond_in), .bit_sel(bit_sel), .bit_sense(bit_sense),
    .mem_byte(mem_byte), .out_valid(out_valid), .ea(ea), .ilen(ilen),
    .next_pc(next_pc), .taken(taken), .tested_bit(tested_bit)
  );

  function automatic exp_t model(input logic [3:0] m, input logic [7:0] a, input logic [7:0] b,
                                 input logic [7:0] x, input logic [15:0] p, input logic c,
                                 input logic [2:0] bs, input logic sn, input logic [7:0] mb,
                                 input string r);
    exp_t e;
    logic [15:0] tgt;
    e.tk = 1'b0; e.tb = 1'b0; e.req = r; e.ea = 16'h0; e.len = 2'd1;
    case (m)
      4'd0: begin e.len = 2; e.ea = p + 16'd1; end
      4'd1, 4'd8: begin e.len = 2; e.ea = {8'h00, a}; end
      4'd2: begin e.len = 3; e.ea = {a, b}; end
      4'd3: begin e.len = 2; e.tk = c; end
      4'd5: begin e.len = 1; e.ea = {8'h00, x}; end
      4'd6: begin e.len = 2; e.ea = 16'(a) + 16'(x); end
      4'd7: begin e.len = 3; e.ea = {a, b} + 16'(x); end
      4'd9: begin e.len = 3; e.ea = {8'h00, a}; e.tb = mb[bs]; e.tk = (mb[bs] == sn); end
      default: begin e.len = 1; e.ea = 16'h0; end
    endcase
    tgt = p + 16'(e.len) + ((m == 4'd9) ? {{8{b[7]}}, b} : {{8{a[7]}}, a});
    if (m == 4'd3) e.ea = tgt;
    e.npc = e.tk ? tgt : p + 16'(e.len);
    return e;
  endfunction

  task automatic send(input logic [3:0] m, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] x, input logic [15:0] p, input logic c,
                      input logic [2:0] bs, input logic sn, input logic [7:0] mb,
                      input string r);
    @(negedge clk); #1;
    mode = m; op1 = a; op2 = b; idx = x; pc = p; cond_in = c;
    bit_sel = bs; bit_sense = sn; mem_byte = mb; in_valid = 1'b1;
    sb.push_back(model(m, a, b, x, p, c, bs, sn, mb, r));
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12: unexpected out_valid, got 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (ea !== e.ea || ilen !== e.len || next_pc !== e.npc ||
            taken !== e.tk || tested_bit !== e.tb) begin
          n_bad++;
          $display("FAIL %s: got ea=%h len=%0d npc=%h tk=%b tb=%b expected ea=%h len=%0d npc=%h tk=%b tb=%b",
                   e.req, ea, ilen, next_pc, taken, tested_bit,
                   e.ea, e.len, e.npc, e.tk, e.tb);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 0 || ea !== 0 || ilen !== 0 || next_pc !== 0 || taken !== 0 || tested_bit !== 0) begin
      n_bad++;
      $display("FAIL R1: got v=%b ea=%h len=%0d npc=%h expected all zero", out_valid, ea, ilen, next_pc);
    end
    #1 rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 0 || ea !== 0) begin
      n_bad++;
      $display("FAIL R1: after release got v=%b ea=%h expected 0 0", out_valid, ea);
    end

    send(4'd0, 8'h12, 8'h00, 8'h00, 16'h1234, 0, 0, 0, 8'h00, "R3");
    send(4'd0, 8'h00, 8'h00, 8'h00, 16'hFFFF, 0, 0, 0, 8'h00, "R3");
    send(4'd1, 8'hC7, 8'h55, 8'h33, 16'h0400, 0, 0, 0, 8'h00, "R4");
    send(4'd8, 8'hFF, 8'h00, 8'h10, 16'h0200, 0, 0, 0, 8'h00, "R4");
    send(4'd2, 8'hAB, 8'hCD, 8'h01, 16'h0100, 0, 0, 0, 8'h00, "R5");
    send(4'd2, 8'hFF, 8'hFF, 8'h00, 16'hFFFE, 0, 0, 0, 8'h00, "R5");
    send(4'd3, 8'h7F, 8'h00, 8'h00, 16'h1000, 1, 0, 0, 8'h00, "R6");
    send(4'd3, 8'h80, 8'h00, 8'h00, 16'h1000, 1, 0, 0, 8'h00, "R6");
    send(4'd3, 8'h80, 8'h00, 8'h00, 16'h1000, 0, 0, 0, 8'h00, "R6");
    send(4'd3, 8'h10, 8'h00, 8'h00, 16'hFFF8, 1, 0, 0, 8'h00, "R6");
    send(4'd4, 8'h99, 8'h88, 8'h77, 16'h0050, 1, 0, 0, 8'hFF, "R2");
    send(4'd5, 8'h00, 8'h00, 8'hE4, 16'h0060, 0, 0, 0, 8'h00, "R7");
    send(4'd6, 8'hFF, 8'h00, 8'hFF, 16'h0070, 0, 0, 0, 8'h00, "R8");
    send(4'd6, 8'h20, 8'h00, 8'h05, 16'h0070, 0, 0, 0, 8'h00, "R8");
    send(4'd7, 8'h12, 8'h34, 8'hFF, 16'h0080, 0, 0, 0, 8'h00, "R9");
    send(4'd7, 8'hFF, 8'hF0, 8'h20, 16'h0080, 0, 0, 0, 8'h00, "R9");
    for (int i = 0; i < 8; i++) begin
      send(4'd9, 8'h40, 8'hFB, 8'h00, 16'h0300, 0, 3'(i), 1'b1, 8'(1 << i), "R10");
      send(4'd9, 8'h41, 8'h05, 8'h00, 16'h0300, 0, 3'(i), 1'b0, 8'(1 << i), "R10");
      send(4'd9, 8'h42, 8'h80, 8'h00, 16'h0300, 0, 3'(i), 1'b0, ~8'(1 << i), "R10");
    end
    for (int m = 10; m < 16; m++)
      send(4'(m), 8'h11, 8'h22, 8'h33, 16'hFFFF, 1, 0, 0, 8'hFF, "R11");
    send(4'd1, 8'h80, 8'h00, 8'h00, 16'hFFFF, 1, 0, 1, 8'hFF, "R11");
    send(4'd7, 8'hFF, 8'hFF, 8'hFF, 16'hFFFE, 1, 0, 1, 8'hFF, "R11");

    // R12: outputs hold through idle cycles, no strobe without a request
    repeat (4) @(negedge clk);
    n_cmp++;
    if (out_valid !== 0 || ea !== 16'h00FE || next_pc !== 16'h0001 || ilen !== 2'd3) begin
      n_bad++;
      $display("FAIL R12: idle got v=%b ea=%h npc=%h len=%0d expected 0 00fe 0001 3",
               out_valid, ea, next_pc, ilen);
    end
    n_cmp++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R12: got %0d pending results expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule